// File: doc/BRIEF.md
# Serial Frame Receiver with Checking

This block takes a non-return-to-zero serial stream, qualified by its own shift clock, and turns it into either a short control frame or a 32-bit command/data word. The shift clock is not used as a clock. It is brought into the system clock domain through a two-stage synchronizer, and each of its rising edges marks one received bit. A frame ends when the line goes quiet for longer than a set number of system clocks. The receiver then judges the frame by its length. A 3-bit or 4-bit frame is a control frame, depending on the selected mode. A frame of 34 bits, or 35 bits when parity is on, is a word.

A received word goes into a 32-bit holding latch, and a strobe tells the host that it has arrived. The host reads the latch through a 16-bit port. The lower half is shown while the upper-half read strobe is high, and the upper half while it is low. The read counts as complete when that strobe goes back high. The latch keeps its contents through a master reset.

In burst mode, a single sync bit and word-identifier bit are followed by many words, each 32 bits long (33 bits with parity). Each word is handed over as soon as its last bit arrives. Sync, parity, bit-count and overrun problems are reported through a sticky two-bit code and an overflow flag. A separate clear input resets both.

Top module: `sfr_rx`

## Requirements
- R1: With `mode_e`=0 a 3-bit frame, and with `mode_e`=1 a 4-bit frame, is a control frame. One clock after the frame ends, `ctl_stb_n` goes low for exactly one clock. At the same time `ctl_data` shows received bit 2, `ctl_cmd` shows bit 3, and `ctl_bit4` shows bit 4 (always 0 when `mode_e`=0).
- R2: In non-burst mode, a frame is a word when it is 34 bits long (`par_en`=0) or 35 bits long (`par_en`=1). Bit 1 is sync and bit 2 is the word identifier. Then come 32 data bits, most significant first, and the parity bit if enabled. The latch, `word_wi`, `word_sync` and `word_par` update, and `word_stb_n` goes low for exactly one clock.
- R3: `rd_data` shows latch bits 15:0 while `rd_hi_n` is 1, and bits 31:16 while `rd_hi_n` is 0.
- R4: `err_code` is 00 for no error, 10 for a bit-count error, 01 for a parity error and 11 for a sync error (sync bit received as 0). A sync error takes precedence over a parity error. A frame without error leaves the code unchanged.
- R5: With `par_en`=1, the 32 data bits plus the parity bit must contain an odd number of ones when `par_odd`=1, and an even number when `par_odd`=0. Otherwise the code becomes 01. With `par_en`=0, nothing is checked.
- R6: A frame of any other length produces code 10 and no strobe.
- R7: If a word is delivered while the previous word has not been read (no rising edge of `rd_hi_n` since its delivery), the latch is overwritten and `ovf` goes to 1 in the same clock as the strobe.
- R8: With `burst_en`=1, after the two header bits, a word is delivered every 32 bits (33 with `par_en`=1). `word_wi` holds the header identifier for all words of the burst. Leftover bits at the end of the burst, or a burst with no complete word, produce code 10.
- R9: `err_clr_n` low clears `err_code` and `ovf` on the next clock, and it takes precedence over a new error arriving in the same clock.
- R10: `rst_n` low clears the strobes, the control outputs, the code, the overflow flag and all sequencing state. It leaves the data latch unchanged.
- R11: A frame ends only after `GAP_CYC` system clocks pass with no rising edge of `rx_clk`. Bits separated by shorter pauses belong to the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Master reset, active low |
| rx_clk | input | 1 | Receive shift clock, one rising edge per bit |
| rx_data | input | 1 | Receive serial data |
| mode_e | input | 1 | 1 = 4-bit control frames, 0 = 3-bit |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| burst_en | input | 1 | Burst reception mode |
| rd_hi_n | input | 1 | Upper-half read strobe, active low |
| err_clr_n | input | 1 | Clear error code and overflow, active low |
| rd_data | output | WORD_W/2 | Selected half of the word latch |
| ctl_stb_n | output | 1 | Control-frame received pulse, active low |
| ctl_data | output | 1 | Bit 2 of last control frame |
| ctl_cmd | output | 1 | Bit 3 of last control frame |
| ctl_bit4 | output | 1 | Bit 4 of last control frame |
| word_stb_n | output | 1 | Word received pulse, active low |
| word_wi | output | 1 | Word identifier of latched word |
| word_sync | output | 1 | Sync bit of latched word |
| word_par | output | 1 | Parity bit of latched word |
| err_code | output | 2 | Sticky error code |
| ovf | output | 1 | Overflow flag |

## Verification
Control frames are sent in both length modes, with good and bad sync bits. This separates the length decision from the sync check. A 4-bit frame sent in the 3-bit mode, and a frame split by a pause shorter than the gap limit, show that classification depends on the mode and the gap, not on bit timing alone. Words are sent with parity off, odd and even parity, and a deliberately wrong parity bit. This separates the parity sense from the parity enable. Bursts with and without parity, one of them ending in leftover bits, test the word pick-off points and the end-of-burst count check. Back-to-back words without a read, followed by a master reset, test overflow and latch retention.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  typedef enum logic [1:0] {
    ERR_NONE = 2'b00,
    ERR_PAR  = 2'b01,
    ERR_CNT  = 2'b10,
    ERR_SYNC = 2'b11
  } err_e;

  // length of a control frame for the selected mode
  function automatic int ctl_bits(input logic mode_e);
    return mode_e ? 4 : 3;
  endfunction

  // payload bits per word: data plus optional parity
  function automatic int payload_bits(input int w, input logic pe);
    return w + (pe ? 1 : 0);
  endfunction

  // complete single-word frame length: sync + identifier + payload
  function automatic int word_frame_bits(input int w, input logic pe);
    return 2 + payload_bits(w, pe);
  endfunction

  // sum is the XOR of all data bits and the parity bit
  function automatic logic parity_bad(input logic pe, input logic odd, input logic sum);
    return pe && (sum != odd);
  endfunction

  function automatic err_e word_err(input logic sync_bit, input logic par_bad);
    if (!sync_bit) return ERR_SYNC;
    if (par_bad)   return ERR_PAR;
    return ERR_NONE;
  endfunction
endpackage

// File: rtl/sfr_rx_sync.sv
module sfr_rx_sync #(
  parameter int GAP_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_clk,
  input  logic rx_data,
  input  logic busy,
  output logic bit_stb,
  output logic bit_val,
  output logic gap
);
  localparam int ICW = $clog2(GAP_CYC + 1);
  localparam logic [ICW-1:0] ILIM = ICW'(GAP_CYC - 1);

  logic [2:0]     ck_sh;
  logic [1:0]     d_sh;
  logic [ICW-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_sh <= '0;
      d_sh  <= '0;
    end else begin
      ck_sh <= {ck_sh[1:0], rx_clk};
      d_sh  <= {d_sh[0], rx_data};
    end
  end

  assign bit_stb = ck_sh[1] & ~ck_sh[2];
  assign bit_val = d_sh[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 idle_cnt <= '0;
    else if (!busy || bit_stb)  idle_cnt <= '0;
    else if (idle_cnt != ILIM)  idle_cnt <= idle_cnt + 1'b1;
  end

  assign gap = busy && !bit_stb && (idle_cnt == ILIM);
endmodule

// File: rtl/sfr_rx_deser.sv
module sfr_rx_deser
  import sfr_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              gap,
  input  logic              mode_e,
  input  logic              par_en,
  input  logic              burst_en,
  output logic              busy,
  output logic              ev_ctl,
  output logic              ev_word,
  output logic              ev_cnt_err,
  output logic [WORD_W-1:0] w_data,
  output logic              w_sync,
  output logic              w_wi,
  output logic              w_par,
  output logic              w_par_sum,
  output logic              c_b0,
  output logic              c_b1,
  output logic              c_b2,
  output logic              c_b3
);
  localparam int BCW = $clog2(WORD_W + 8) + 1;
  localparam int WCW = $clog2(WORD_W + 2);

  logic [BCW-1:0]    bcnt;
  logic [WCW-1:0]    wcnt;
  logic [WORD_W-1:0] sh;
  logic              pacc, lastbit, got_word;
  logic              in_payload, pick, ctl_hit, word_hit, burst_ok;

  assign busy       = (bcnt != '0);
  assign in_payload = (int'(bcnt) >= 2);
  assign pick       = bit_stb && burst_en && in_payload &&
                      (int'(wcnt) == payload_bits(WORD_W, par_en) - 1);
  assign ctl_hit    = (int'(bcnt) == ctl_bits(mode_e));
  assign word_hit   = !burst_en && (int'(bcnt) == word_frame_bits(WORD_W, par_en));
  assign burst_ok   = burst_en && got_word && (wcnt == '0);

  assign ev_ctl     = gap && ctl_hit;
  assign ev_word    = pick || (gap && !ctl_hit && word_hit);
  assign ev_cnt_err = gap && !ctl_hit && !word_hit && !burst_ok;

  assign w_data    = (pick && !par_en) ? {sh[WORD_W-2:0], bit_val} : sh;
  assign w_par     = pick ? bit_val : lastbit;
  assign w_par_sum = pick ? (pacc ^ bit_val) : pacc;
  assign w_sync    = c_b0;
  assign w_wi      = c_b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0; wcnt <= '0; pacc <= 1'b0; got_word <= 1'b0; lastbit <= 1'b0;
      c_b0 <= 1'b0; c_b1 <= 1'b0; c_b2 <= 1'b0; c_b3 <= 1'b0;
    end else if (gap) begin
      bcnt <= '0; wcnt <= '0; pacc <= 1'b0; got_word <= 1'b0;
    end else if (bit_stb) begin
      if (bcnt != '1) bcnt <= bcnt + 1'b1;
      lastbit <= bit_val;
      case (int'(bcnt))
        0: c_b0 <= bit_val;
        1: c_b1 <= bit_val;
        2: c_b2 <= bit_val;
        3: c_b3 <= bit_val;
        default: ;
      endcase
      if (in_payload) begin
        if (pick) begin
          wcnt     <= '0;
          pacc     <= 1'b0;
          got_word <= 1'b1;
        end else begin
          if (wcnt != '1) wcnt <= wcnt + 1'b1;
          pacc <= pacc ^ bit_val;
        end
      end
    end
  end

  // data shift: only the first WORD_W payload bits of each word enter
  always_ff @(posedge clk) begin
    if (bit_stb && !gap && in_payload && (int'(wcnt) < WORD_W))
      sh <= {sh[WORD_W-2:0], bit_val};
  end
endmodule

// File: rtl/sfr_rx_flags.sv
module sfr_rx_flags
  import sfr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       err_clr_n,
  input  logic       rd_hi_n,
  input  logic       ev_word,
  input  err_e       new_err,
  output logic [1:0] err_code,
  output logic       ovf,
  output logic       rd_done
);
  logic rd_hi_q, unread;

  assign rd_done = rd_hi_n & ~rd_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_hi_q  <= 1'b1;
      unread   <= 1'b0;
      err_code <= 2'b00;
      ovf      <= 1'b0;
    end else begin
      rd_hi_q <= rd_hi_n;
      if (ev_word)      unread <= 1'b1;
      else if (rd_done) unread <= 1'b0;
      if (!err_clr_n) begin
        err_code <= 2'b00;
        ovf      <= 1'b0;
      end else begin
        if (new_err != ERR_NONE) err_code <= new_err;
        if (ev_word && unread && !rd_done) ovf <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sfr_rx.sv
module sfr_rx
  import sfr_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int GAP_CYC = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_clk,
  input  logic                rx_data,
  input  logic                mode_e,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                burst_en,
  input  logic                rd_hi_n,
  input  logic                err_clr_n,
  output logic [WORD_W/2-1:0] rd_data,
  output logic                ctl_stb_n,
  output logic                ctl_data,
  output logic                ctl_cmd,
  output logic                ctl_bit4,
  output logic                word_stb_n,
  output logic                word_wi,
  output logic                word_sync,
  output logic                word_par,
  output logic [1:0]          err_code,
  output logic                ovf
);
  localparam int HALF = WORD_W / 2;

  logic              bit_stb, bit_val, ev_gap, busy;
  logic              ev_ctl, ev_word, ev_cnt_err, rd_done;
  logic [WORD_W-1:0] w_data, lat;
  logic              w_sync, w_wi, w_par, w_par_sum;
  logic              c_b0, c_b1, c_b2, c_b3;
  err_e              new_err;

  sfr_rx_sync #(.GAP_CYC(GAP_CYC)) u_sync (
    .clk(clk), .rst_n(rst_n), .rx_clk(rx_clk), .rx_data(rx_data),
    .busy(busy), .bit_stb(bit_stb), .bit_val(bit_val), .gap(ev_gap)
  );

  sfr_rx_deser #(.WORD_W(WORD_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val), .gap(ev_gap),
    .mode_e(mode_e), .par_en(par_en), .burst_en(burst_en), .busy(busy),
    .ev_ctl(ev_ctl), .ev_word(ev_word), .ev_cnt_err(ev_cnt_err),
    .w_data(w_data), .w_sync(w_sync), .w_wi(w_wi), .w_par(w_par), .w_par_sum(w_par_sum),
    .c_b0(c_b0), .c_b1(c_b1), .c_b2(c_b2), .c_b3(c_b3)
  );

  always_comb begin
    new_err = ERR_NONE;
    if (ev_cnt_err)   new_err = ERR_CNT;
    else if (ev_ctl)  new_err = c_b0 ? ERR_NONE : ERR_SYNC;
    else if (ev_word) new_err = word_err(w_sync, parity_bad(par_en, par_odd, w_par_sum));
  end

  sfr_rx_flags u_flags (
    .clk(clk), .rst_n(rst_n), .err_clr_n(err_clr_n), .rd_hi_n(rd_hi_n),
    .ev_word(ev_word), .new_err(new_err), .err_code(err_code), .ovf(ovf),
    .rd_done(rd_done)
  );

  // word latch: deliberately outside the master reset
  always_ff @(posedge clk) begin
    if (ev_word) begin
      lat       <= w_data;
      word_wi   <= w_wi;
      word_sync <= w_sync;
      word_par  <= w_par;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_stb_n  <= 1'b1;
      word_stb_n <= 1'b1;
      ctl_data   <= 1'b0;
      ctl_cmd    <= 1'b0;
      ctl_bit4   <= 1'b0;
    end else begin
      ctl_stb_n  <= ~ev_ctl;
      word_stb_n <= ~ev_word;
      if (ev_ctl) begin
        ctl_data <= c_b1;
        ctl_cmd  <= c_b2;
        ctl_bit4 <= mode_e & c_b3;
      end
    end
  end

  assign rd_data = rd_hi_n ? lat[HALF-1:0] : lat[WORD_W-1:HALF];
endmodule

// File: rtl/sfr_rx_chk.sv
module sfr_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       err_clr_n,
  input logic       ctl_stb_n,
  input logic       word_stb_n,
  input logic       ovf,
  input logic [1:0] err_code,
  input logic       ev_gap
);
  p_ctl_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_stb_n |=> ctl_stb_n);

  p_word_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !word_stb_n |=> word_stb_n);

  p_one_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ctl_stb_n && !word_stb_n));

  p_ovf_with_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> !word_stb_n);

  p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clr_n |=> (err_code == 2'b00 && !ovf));

  p_ctl_after_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_stb_n) |-> $past(ev_gap));
endmodule

bind sfr_rx sfr_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .err_clr_n(err_clr_n), .ctl_stb_n(ctl_stb_n),
  .word_stb_n(word_stb_n), .ovf(ovf), .err_code(err_code), .ev_gap(ev_gap)
);

// File: tb/sfr_rx_bench.sv
module sfr_rx_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, rx_clk = 1'b0, rx_data = 1'b0;
  logic mode_e = 1'b0, par_en = 1'b0, par_odd = 1'b1, burst_en = 1'b0;
  logic rd_hi_n = 1'b1, err_clr_n = 1'b1;
  logic [15:0] rd_data;
  logic ctl_stb_n, ctl_data, ctl_cmd, ctl_bit4, word_stb_n;
  logic word_wi, word_sync, word_par, ovf;
  logic [1:0] err_code;

  sfr_rx #(.WORD_W(32), .GAP_CYC(8)) u_sfr_rx (
    .clk(clk), .rst_n(rst_n), .rx_clk(rx_clk), .rx_data(rx_data),
    .mode_e(mode_e), .par_en(par_en), .par_odd(par_odd), .burst_en(burst_en),
    .rd_hi_n(rd_hi_n), .err_clr_n(err_clr_n), .rd_data(rd_data),
    .ctl_stb_n(ctl_stb_n), .ctl_data(ctl_data), .ctl_cmd(ctl_cmd), .ctl_bit4(ctl_bit4),
    .word_stb_n(word_stb_n), .word_wi(word_wi), .word_sync(word_sync),
    .word_par(word_par), .err_code(err_code), .ovf(ovf)
  );

  typedef struct {
    bit          is_ctl;
    logic [31:0] data;
    logic        wi;
    logic [1:0]  err;
    logic        b2, b3, b4;
  } exp_t;

  exp_t        expq[$];
  logic        txq[$];
  int          n_cmp = 0, n_bad = 0, n_strobes = 0;
  logic [1:0]  err_m = 2'b00;
  logic        ovf_m = 1'b0, unread_m = 1'b0;
  bit          done = 1'b0;
  logic [31:0] last_word = 32'h0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model, evaluated at every clock: strobes are matched to expectations
  always @(negedge clk) begin
    if (rst_n && !done && (!ctl_stb_n || !word_stb_n)) begin
      n_strobes++;
      if (expq.size() == 0) begin
        check("R6 unexpected strobe", {30'h0, ctl_stb_n, word_stb_n}, 32'h3);
      end else begin
        exp_t e;
        e = expq.pop_front();
        if (e.err != 2'b00) err_m = e.err;
        if (e.is_ctl) begin
          check("R1 control strobe", {31'h0, ctl_stb_n}, 32'h0);
          check("R1 data flag", {31'h0, ctl_data}, {31'h0, e.b2});
          check("R1 command flag", {31'h0, ctl_cmd}, {31'h0, e.b3});
          check("R1 bit four", {31'h0, ctl_bit4}, {31'h0, e.b4});
          check("R4 code after control", {30'h0, err_code}, {30'h0, err_m});
        end else begin
          if (unread_m) ovf_m = 1'b1;
          unread_m  = 1'b1;
          last_word = e.data;
          check("R2 word strobe", {31'h0, word_stb_n}, 32'h0);
          check("R8 word identifier", {31'h0, word_wi}, {31'h0, e.wi});
          check("R3 lower half at strobe", {16'h0, rd_data}, {16'h0, e.data[15:0]});
          check("R4 code after word", {30'h0, err_code}, {30'h0, err_m});
          check("R7 overflow at strobe", {31'h0, ovf}, {31'h0, ovf_m});
        end
      end
    end
  end

  task automatic send_bit(input logic b);
    @(negedge clk) rx_data = b;
    repeat (2) @(negedge clk);
    rx_clk = 1'b1;
    repeat (2) @(negedge clk);
    rx_clk = 1'b0;
  endtask

  task automatic add_data(input logic [31:0] d, input bit with_p, input logic pb);
    for (int i = 31; i >= 0; i--) txq.push_back(d[i]);
    if (with_p) txq.push_back(pb);
  endtask

  function automatic logic good_par(input logic [31:0] d, input logic odd);
    return (($countones(d) % 2) == 1) != odd;
  endfunction

  task automatic expect_word(input int base, input int w);
    exp_t e;
    int   ones;
    e.is_ctl = 1'b0;
    e.data   = '0;
    for (int i = 0; i < 32; i++) e.data = {e.data[30:0], txq[base + i]};
    ones = $countones(e.data);
    if (par_en) ones += int'(txq[base + 32]);
    e.wi = txq[1];
    if (!txq[0])                                       e.err = 2'b11;
    else if (par_en && ((ones % 2 == 1) != par_odd))   e.err = 2'b01;
    else                                               e.err = 2'b00;
    e.b2 = 1'b0; e.b3 = 1'b0; e.b4 = 1'b0;
    expq.push_back(e);
    if (w == 0) e.wi = 1'b0;
  endtask

  // classify the queued frame independently, send it, then check the final state
  task automatic run_frame(input string tag, input int split_after);
    int n, cl, w, k;
    bit cnt_err;
    n = txq.size(); cl = mode_e ? 4 : 3; w = 32 + (par_en ? 1 : 0); cnt_err = 0;
    if (n == cl) begin
      exp_t e;
      e.is_ctl = 1'b1; e.data = '0; e.wi = 1'b0;
      e.err = txq[0] ? 2'b00 : 2'b11;
      e.b2 = txq[1]; e.b3 = txq[2]; e.b4 = mode_e ? txq[3] : 1'b0;
      expq.push_back(e);
    end else if (!burst_en) begin
      if (n == w + 2) expect_word(2, w);
      else cnt_err = 1;
    end else begin
      k = (n < 2) ? 0 : (n - 2) / w;
      for (int j = 0; j < k; j++) expect_word(2 + j * w, w);
      if (k == 0 || (n - 2) % w != 0) cnt_err = 1;
    end
    for (int i = 0; i < n; i++) begin
      send_bit(txq[i]);
      if (i == split_after) repeat (2) @(negedge clk);
    end
    txq.delete();
    repeat (24) @(negedge clk);
    if (cnt_err) err_m = 2'b10;
    check({tag, " final code"}, {30'h0, err_code}, {30'h0, err_m});
    check({tag, " all strobes seen"}, expq.size(), 0);
  endtask

  task automatic read_word(input string tag, input logic [31:0] exp);
    @(negedge clk);
    check({tag, " R3 lower half"}, {16'h0, rd_data}, {16'h0, exp[15:0]});
    rd_hi_n = 1'b0;
    @(negedge clk);
    check({tag, " R3 upper half"}, {16'h0, rd_data}, {16'h0, exp[31:16]});
    rd_hi_n = 1'b1;
    repeat (2) @(negedge clk);
    unread_m = 1'b0;
  endtask

  task automatic clear_err(input string tag);
    @(negedge clk) err_clr_n = 1'b0;
    @(negedge clk) err_clr_n = 1'b1;
    err_m = 2'b00; ovf_m = 1'b0;
    check({tag, " R9 code cleared"}, {30'h0, err_code}, 32'h0);
    check({tag, " R9 overflow cleared"}, {31'h0, ovf}, 32'h0);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL R11 watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int s0;
    repeat (5) @(negedge clk);
    // R10 reset state
    check("R10 ctl strobe idle", {31'h0, ctl_stb_n}, 32'h1);
    check("R10 word strobe idle", {31'h0, word_stb_n}, 32'h1);
    check("R10 code reset", {30'h0, err_code}, 32'h0);
    check("R10 overflow reset", {31'h0, ovf}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 short control frame
    mode_e = 1'b0;
    txq = '{1'b1, 1'b1, 1'b0};
    run_frame("R1 3-bit control", -1);

    // R1 long control frame
    mode_e = 1'b1;
    txq = '{1'b1, 1'b0, 1'b1, 1'b1};
    run_frame("R1 4-bit control", -1);

    // R4 sync error on a control frame, then R9 clear
    txq = '{1'b0, 1'b1, 1'b1, 1'b0};
    run_frame("R4 control sync error", -1);
    check("R4 sync code", {30'h0, err_code}, 32'h3);
    clear_err("R9 after sync");

    // R2 plain word, no parity
    mode_e = 1'b0; par_en = 1'b0;
    txq = '{1'b1, 1'b1};
    add_data(32'hA5C3_0F96, 0, 1'b0);
    run_frame("R2 word no parity", -1);
    check("R2 sync bit", {31'h0, word_sync}, 32'h1);
    read_word("R2 read", 32'hA5C3_0F96);

    // R5 odd parity correct
    par_en = 1'b1; par_odd = 1'b1;
    txq = '{1'b1, 1'b0};
    add_data(32'h0000_0007, 1, good_par(32'h0000_0007, 1'b1));
    run_frame("R5 odd good", -1);
    check("R5 odd good code", {30'h0, err_code}, 32'h0);
    check("R2 parity bit latched", {31'h0, word_par}, 32'h0);
    read_word("R5 read", 32'h0000_0007);

    // R5 odd parity wrong
    txq = '{1'b1, 1'b0};
    add_data(32'h0000_0007, 1, 1'b1);
    run_frame("R5 odd bad", -1);
    check("R5 parity code", {30'h0, err_code}, 32'h1);
    read_word("R5 read bad", 32'h0000_0007);
    clear_err("R9 after parity");

    // R5 even parity correct
    par_odd = 1'b0;
    txq = '{1'b1, 1'b1};
    add_data(32'h8000_0001, 1, good_par(32'h8000_0001, 1'b0));
    run_frame("R5 even good", -1);
    check("R5 even code", {30'h0, err_code}, 32'h0);
    read_word("R5 read even", 32'h8000_0001);

    // R4 sync beats parity
    par_odd = 1'b1;
    txq = '{1'b0, 1'b1};
    add_data(32'h0000_0001, 1, 1'b1);
    run_frame("R4 sync over parity", -1);
    check("R4 sync precedence", {30'h0, err_code}, 32'h3);
    read_word("R4 read", 32'h0000_0001);
    clear_err("R9 after sync word");

    // R6 odd length
    par_en = 1'b0;
    s0 = n_strobes;
    txq = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
    run_frame("R6 10-bit frame", -1);
    check("R6 count code", {30'h0, err_code}, 32'h2);
    check("R6 no strobe", n_strobes, s0);
    clear_err("R9 after count");

    // R1 four bits in three-bit mode is a count error
    txq = '{1'b1, 1'b1, 1'b0, 1'b1};
    run_frame("R1 wrong mode length", -1);
    check("R1 4 bits rejected in mode 0", {30'h0, err_code}, 32'h2);
    clear_err("R9 after mode");

    // R11 short pause inside a frame joins the bits
    s0 = n_strobes;
    txq = '{1'b1, 1'b1, 1'b0, 1'b1};
    run_frame("R11 split frame", 2);
    check("R11 no control strobe", n_strobes, s0);
    clear_err("R9 after split");

    // R7 overflow on unread word
    txq = '{1'b1, 1'b0};
    add_data(32'h1234_5678, 0, 1'b0);
    run_frame("R7 first word", -1);
    txq = '{1'b1, 1'b0};
    add_data(32'h9ABC_DEF0, 0, 1'b0);
    run_frame("R7 second word", -1);
    check("R7 overflow set", {31'h0, ovf}, 32'h1);
    read_word("R7 overwritten", 32'h9ABC_DEF0);
    clear_err("R9 after overflow");
    txq = '{1'b1, 1'b0};
    add_data(32'h0F0F_F0F0, 0, 1'b0);
    run_frame("R7 word after read", -1);
    check("R7 no overflow after read", {31'h0, ovf}, 32'h0);
    read_word("R7 read", 32'h0F0F_F0F0);

    // R8 burst, no parity, two words
    burst_en = 1'b1;
    txq = '{1'b1, 1'b1};
    add_data(32'hDEAD_BEEF, 0, 1'b0);
    add_data(32'h0123_4567, 0, 1'b0);
    run_frame("R8 burst", -1);
    read_word("R8 second word", 32'h0123_4567);
    clear_err("R9 after burst");

    // R8 burst with parity and trailing bits
    par_en = 1'b1; par_odd = 1'b1;
    txq = '{1'b1, 1'b0};
    add_data(32'hCAFE_0001, 1, good_par(32'hCAFE_0001, 1'b1));
    add_data(32'h5555_AAAA, 1, good_par(32'h5555_AAAA, 1'b1));
    for (int i = 0; i < 5; i++) txq.push_back(1'b1);
    run_frame("R8 burst leftover", -1);
    check("R8 leftover count code", {30'h0, err_code}, 32'h2);
    check("R8 identifier held", {31'h0, word_wi}, 32'h0);

    // R10 master reset keeps latch
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check("R10 code after reset", {30'h0, err_code}, 32'h0);
    check("R10 overflow after reset", {31'h0, ovf}, 32'h0);
    rst_n = 1'b1;
    err_m = 2'b00; ovf_m = 1'b0; unread_m = 1'b0;
    read_word("R10 latch retained", 32'h5555_AAAA);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule